// File: doc/BRIEF.md
# Flow-Through Burst Memory Data Path

This block is the data half of a synchronous burst memory with flow-through reads. A separate burst address generator presents, ahead of each rising clock edge, the address of the beat that edge opens; this block registers it, decides from the strobes, chip select and write controls whether the edge writes, reads or does nothing, and updates a small word array made of 8-bit lanes. Read data leaves the array combinationally from the registered address, so a read word is visible in the same cycle that the address was taken.

The three-state data pins are modelled by a read-data bus and a drive flag. The flag follows the asynchronous active-low output enable, is dropped in any cycle that follows a write edge, and is held low in the first cycle of a read that starts from the idle or deselected state. An asynchronous sleep request is brought in through two flops, so entry and exit each cost two edges. The array keeps its contents while asleep, any access in flight is abandoned, and after wake-up a programmable number of edges ignore new access starts.

Top module: `fts_dataside`

## Requirements
- R1: With `gwr_n` low on a writing edge, all four lanes take `wdata`, whatever `bwe_n` and `bsel_n` hold.
- R2: With `gwr_n` high, a write needs `bwe_n` low; lane i (bits 8i+7:8i, `bsel_n[0]` for bits 7:0 up to `bsel_n[3]` for bits 31:24) is written only when `bsel_n[i]` is low. With `bwe_n` and `gwr_n` both high, the edge reads and nothing is written.
- R3: On an edge with `sel` high and `pstb_n` low the write controls are ignored and the edge reads; a following edge with both strobes high and a write request writes `wdata` to `beat_addr`.
- R4: On an edge with `sel` high, `pstb_n` high and `cstb_n` low, a write request writes on that same edge; if `pstb_n` is also low, the processor start wins and nothing is written.
- R5: After a reading edge, `rdata` shows the word at the address registered on that edge within the same cycle.
- R6: `drive` follows `oe_n` (active low) with no clock edge in between; `rdata` is zero whenever `drive` is low.
- R7: In the cycle after any writing edge, `drive` is low even with `oe_n` low.
- R8: In the cycle after an access start made while no access was open, `drive` is low; on the next reading edge it rises.
- R9: A `sleep` level held high is seen after two edges: `drive` stays high after the first and is low after the second; while asleep no write happens, the open access is dropped and the array is kept.
- R10: After `sleep` falls, two edges end the sleep and the next `REC_CYC` edges (default 2) ignore access starts; the edge after that accepts one.
- R11: A strobe (`pstb_n` or `cstb_n` low) with `sel` low closes the open access; `drive` is then low.
- R12: After reset `drive` is low, `rdata` is zero and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Combined chip select, high when every enable is active |
| pstb_n | input | 1 | Processor access strobe, active low |
| cstb_n | input | 1 | Controller access strobe, active low |
| beat_addr | input | AW | Address of the beat this edge opens, from the burst generator |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low, bit 0 for bits 7:0 |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| rdata | output | 32 | Read word, zero when not driven |
| drive | output | 1 | High when the data bus would be driven |

## Verification
The two functions that can meet in one cycle are sleep handling and access decoding: a sleep request rises while a burst is still reading, and controller writes are offered both while asleep and on the very edges of the wake-up window. The bench places those writes on exactly the edges that must be refused and a processor start on the first edge that must be accepted, then judges the result by the drive flag and by the word read back from the contested address, which must still hold its pre-sleep value.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int LANE_W = 8;

  // What a clock edge does to the access state
  typedef enum logic [2:0] {
    EV_IDLE    = 3'd0,
    EV_BLOCK   = 3'd1,
    EV_START_P = 3'd2,
    EV_START_C = 3'd3,
    EV_CONT    = 3'd4,
    EV_DESEL   = 3'd5
  } edge_ev_t;

endpackage

// File: rtl/fts_wr_decode.sv
module fts_wr_decode #(
  parameter int NLANE = 4
) (
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [NLANE-1:0] bsel_n,
  output logic [NLANE-1:0] lanes,
  output logic             wr_req
);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    // global write overrides the byte path
    assign lanes[g] = ~gwr_n | (~bwe_n & ~bsel_n[g]);
  end

  assign wr_req = |lanes;

endmodule

// File: rtl/fts_sleep_ctl.sv
module fts_sleep_ctl #(
  parameter int REC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic asleep,
  output logic blocked
);

  localparam int RW = (REC_CYC < 1) ? 1 : $clog2(REC_CYC + 1);
  localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYC);

  logic          s1_q, s1_d;
  logic          s2_q, s2_d;
  logic [RW-1:0] rec_q, rec_d;

  always_comb begin
    s1_d  = sleep;
    s2_d  = s1_q;
    rec_d = rec_q;
    if (s2_q && !s1_q) begin
      rec_d = REC_LOAD;
    end else if (rec_q != '0) begin
      rec_d = rec_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      rec_q <= '0;
    end else begin
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      rec_q <= rec_d;
    end
  end

  assign asleep  = s2_q;
  assign blocked = s2_q | (rec_q != '0);

endmodule

// File: rtl/fts_access_ctl.sv
module fts_access_ctl
  import fts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic pstb_n,
  input  logic cstb_n,
  input  logic wr_req,
  input  logic blocked,
  input  logic asleep,
  output logic we,
  output logic load,
  output logic act_q,
  output logic wr_q,
  output logic mask_q
);

  edge_ev_t ev;
  logic     act_d, wr_d, mask_d;
  logic     is_start;

  always_comb begin
    if (blocked) begin
      ev = EV_BLOCK;
    end else if (sel && !pstb_n) begin
      ev = EV_START_P;
    end else if (sel && !cstb_n) begin
      ev = EV_START_C;
    end else if (!sel && (!pstb_n || !cstb_n)) begin
      ev = EV_DESEL;
    end else if (act_q) begin
      ev = EV_CONT;
    end else begin
      ev = EV_IDLE;
    end
  end

  assign is_start = (ev == EV_START_P) || (ev == EV_START_C);
  assign we       = ((ev == EV_START_C) || (ev == EV_CONT)) && wr_req;
  assign load     = is_start || (ev == EV_CONT);

  always_comb begin
    act_d  = act_q;
    if (asleep) begin
      act_d = 1'b0;
    end else if (is_start) begin
      act_d = 1'b1;
    end else if (ev == EV_DESEL) begin
      act_d = 1'b0;
    end
    wr_d   = we;
    mask_d = is_start && !act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/fts_store.sv
module fts_store #(
  parameter int DEPTH = 64,
  parameter int NLANE = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = NLANE * fts_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NLANE-1:0] lanes,
  input  logic             load,
  input  logic [AW-1:0]    beat_addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    word
);

  localparam int LW = fts_pkg::LANE_W;

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) addr_d = beat_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lanes[g]) mem[beat_addr] <= wdata[g*LW +: LW];
    end
    // flow-through: no output register
    assign word[g*LW +: LW] = mem[addr_q];
  end

endmodule

// File: rtl/fts_dataside.sv
module fts_dataside #(
  parameter int DEPTH   = 64,
  parameter int DATA_W  = 32,
  parameter int REC_CYC = 2,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic [AW-1:0]     beat_addr,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [DATA_W/8-1:0] bsel_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);

  localparam int NLANE = DATA_W / fts_pkg::LANE_W;

  logic [NLANE-1:0]  lanes_w;
  logic              wr_req_w;
  logic              asleep_w, blocked_w;
  logic              we_w, load_w, act_w, wrq_w, mask_w;
  logic [DATA_W-1:0] word_w;

  fts_wr_decode #(.NLANE(NLANE)) u_dec (
    .gwr_n  (gwr_n),
    .bwe_n  (bwe_n),
    .bsel_n (bsel_n),
    .lanes  (lanes_w),
    .wr_req (wr_req_w)
  );

  fts_sleep_ctl #(.REC_CYC(REC_CYC)) u_slp (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .asleep  (asleep_w),
    .blocked (blocked_w)
  );

  fts_access_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .pstb_n  (pstb_n),
    .cstb_n  (cstb_n),
    .wr_req  (wr_req_w),
    .blocked (blocked_w),
    .asleep  (asleep_w),
    .we      (we_w),
    .load    (load_w),
    .act_q   (act_w),
    .wr_q    (wrq_w),
    .mask_q  (mask_w)
  );

  fts_store #(.DEPTH(DEPTH), .NLANE(NLANE), .AW(AW), .DW(DATA_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we_w),
    .lanes     (lanes_w),
    .load      (load_w),
    .beat_addr (beat_addr),
    .wdata     (wdata),
    .word      (word_w)
  );

  assign drive = act_w & ~wrq_w & ~mask_w & ~oe_n & ~asleep_w;
  assign rdata = drive ? word_w : '0;

endmodule

// File: rtl/fts_dataside_chk.sv
module fts_dataside_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive,
  input logic [DATA_W-1:0] rdata,
  input logic              oe_n,
  input logic              pstb_n,
  input logic              sel,
  input logic              we,
  input logic              asleep,
  input logic              blocked,
  input logic              act_q,
  input logic              mask_q
);

  // R7
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !drive);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive);

  // R6
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (rdata == '0));

  // R9
  sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !we);

  // R10
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !act_q);

  // R8
  first_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !drive);

  // R4
  cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !pstb_n && !blocked) |-> !we);

endmodule

bind fts_dataside fts_dataside_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drive   (drive),
  .rdata   (rdata),
  .oe_n    (oe_n),
  .pstb_n  (pstb_n),
  .sel     (sel),
  .we      (we_w),
  .asleep  (asleep_w),
  .blocked (blocked_w),
  .act_q   (act_w),
  .mask_q  (mask_w)
);

// File: tb/sim_fts_dataside.sv
module sim_fts_dataside;

  localparam int CLK_P = 10;
  localparam int AW    = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, pstb_n, cstb_n, gwr_n, bwe_n, oe_n, sleep;
  logic [AW-1:0] beat_addr;
  logic [3:0]  bsel_n;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        drive;

  int total = 0;
  int bad   = 0;
  logic [31:0] ref_mem [64];

  always #(CLK_P/2) clk = ~clk;

  fts_dataside u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .beat_addr(beat_addr), .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .drive(drive)
  );

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw,
                                        logic g_n, logic b_n, logic [3:0] s_n);
    logic [31:0] r;
    r = old;
    if (!g_n) return nw;
    if (b_n) return old;
    for (int i = 0; i < 4; i++) if (!s_n[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic wr_on(logic g_n, logic b_n, logic [3:0] s_n);
    return !g_n || (!b_n && (s_n != 4'hF));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle();
    pstb_n = 1'b1; cstb_n = 1'b1;
    gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
  endtask

  // controller-strobe access; write if controls ask (R4), else read (R2)
  task automatic ctl_access(logic [AW-1:0] a, logic g_n, logic b_n,
                            logic [3:0] s_n, logic [31:0] d);
    logic w;
    sel = 1'b1; beat_addr = a; pstb_n = 1'b1; cstb_n = 1'b0;
    gwr_n = g_n; bwe_n = b_n; bsel_n = s_n; wdata = d;
    w = wr_on(g_n, b_n, s_n);
    step();
    if (w) begin
      ref_mem[a] = merge(ref_mem[a], d, g_n, b_n, s_n);
      chk("R7 drive after write", {31'd0, drive}, 32'd0);
    end else begin
      chk("R2 no-write read drive", {31'd0, drive}, 32'd1);
      chk("R5 flow-through on start", rdata, ref_mem[a]);
    end
    idle();
    step();
    chk("R5 drive on read beat", {31'd0, drive}, 32'd1);
    chk("R1/R2 lane result", rdata, ref_mem[a]);
  endtask

  // processor-strobe access: first-edge controls ignored (R3)
  task automatic cpu_access(logic [AW-1:0] a, logic g1, logic b1, logic [3:0] s1,
                            logic g2, logic b2, logic [3:0] s2, logic [31:0] d);
    logic w;
    sel = 1'b1; beat_addr = a; pstb_n = 1'b0; cstb_n = 1'b1;
    gwr_n = g1; bwe_n = b1; bsel_n = s1; wdata = ~d;
    step();
    chk("R3 start edge reads", {31'd0, drive}, 32'd1);
    chk("R3 start edge data kept", rdata, ref_mem[a]);
    pstb_n = 1'b1; gwr_n = g2; bwe_n = b2; bsel_n = s2; wdata = d;
    w = wr_on(g2, b2, s2);
    step();
    if (w) begin
      ref_mem[a] = merge(ref_mem[a], d, g2, b2, s2);
      chk("R7 drive after beat write", {31'd0, drive}, 32'd0);
    end
    idle();
    step();
    chk("R3 second-edge result", rdata, ref_mem[a]);
  endtask

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C5A));
    rst_n = 1'b0; sel = 1'b1; idle(); beat_addr = '0; wdata = '0;
    oe_n = 1'b0; sleep = 1'b0;
    repeat (3) step();
    // R12
    chk("R12 drive at reset", {31'd0, drive}, 32'd0);
    chk("R12 rdata at reset", rdata, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R12 idle after reset", {31'd0, drive}, 32'd0);

    // fill with global writes (R1: byte controls set against it)
    for (int i = 0; i < 16; i++)
      ctl_access(AW'(i), 1'b0, 1'b1, 4'hF, 32'h3C00_0000 + 32'(i * 32'h0101_0101));

    // R2 lanes 0 and 2
    ctl_access(6'd5, 1'b1, 1'b0, 4'b1010, 32'h1122_3344);
    chk("R2 lanes 0,2 only", ref_mem[5], merge(32'h3C00_0000 + 32'h0505_0505, 32'h1122_3344, 1'b1, 1'b0, 4'b1010));
    // R2 byte selects with bwe_n high: a read
    ctl_access(6'd6, 1'b1, 1'b1, 4'h0, 32'hFFFF_FFFF);
    // R1 global with all byte selects off
    ctl_access(6'd4, 1'b0, 1'b1, 4'hF, 32'hA5A5_5A5A);

    // R3: controls ignored at processor start, honoured on next edge
    cpu_access(6'd7, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 4'hF, 32'hCAFE_0007);

    // R4: both strobes low, processor wins, no write
    sel = 1'b1; beat_addr = 6'd8; pstb_n = 1'b0; cstb_n = 1'b0; gwr_n = 1'b0; wdata = 32'h0BAD_0008;
    step();
    chk("R4 precedence no write", rdata, ref_mem[8]);
    idle(); step();
    chk("R4 word kept", rdata, ref_mem[8]);

    // R6: combinational output enable
    oe_n = 1'b1; #1;
    chk("R6 drive off", {31'd0, drive}, 32'd0);
    chk("R6 rdata zero", rdata, 32'd0);
    oe_n = 1'b0; #1;
    chk("R6 drive back", {31'd0, drive}, 32'd1);

    // R11 deselect, then R8 mask on first read
    sel = 1'b0; cstb_n = 1'b0; step();
    chk("R11 deselected", {31'd0, drive}, 32'd0);
    idle(); sel = 1'b1; step();
    chk("R11 stays closed", {31'd0, drive}, 32'd0);
    beat_addr = 6'd9; pstb_n = 1'b0; step();
    chk("R8 first read masked", {31'd0, drive}, 32'd0);
    idle(); step();
    chk("R8 second cycle drives", {31'd0, drive}, 32'd1);
    chk("R8 data", rdata, ref_mem[9]);

    // R9 sleep entry during an open read
    sleep = 1'b1; step();
    chk("R9 one edge still awake", {31'd0, drive}, 32'd1);
    step();
    chk("R9 asleep after two", {31'd0, drive}, 32'd0);
    beat_addr = 6'd10; cstb_n = 1'b0; gwr_n = 1'b0; wdata = 32'hDEAD_0010; step();
    chk("R9 no drive asleep", {31'd0, drive}, 32'd0);
    idle(); sleep = 1'b0;
    step(); step();
    // R10 recovery: two edges of refused starts
    beat_addr = 6'd10; cstb_n = 1'b0; gwr_n = 1'b0; wdata = 32'hBEEF_0010;
    step();
    chk("R10 start refused", {31'd0, drive}, 32'd0);
    step();
    chk("R10 start refused again", {31'd0, drive}, 32'd0);
    idle(); pstb_n = 1'b0; step();
    chk("R10 R8 accepted start masked", {31'd0, drive}, 32'd0);
    idle(); step();
    chk("R10 accepted after window", {31'd0, drive}, 32'd1);
    chk("R9 contents kept through sleep", rdata, ref_mem[10]);
    ctl_access(6'd4, 1'b1, 1'b1, 4'hF, 32'h0);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0)
        ctl_access(a, 1'($urandom_range(0, 3) == 0), 1'($urandom), 4'($urandom), $urandom);
      else
        cpu_access(a, 1'($urandom), 1'($urandom), 4'($urandom),
                   1'($urandom_range(0, 3) == 0), 1'($urandom), 4'($urandom), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule